// File: doc/BRIEF.md
# Codec Register Access Controller

This block is a word-addressed slave through which a processor asks an external audio codec to read or write one of its internal registers. Software loads a codec register address and, for writes, the value to send. It then writes the control word. Setting the request bit in that control word launches the transaction. The direction bit chooses which of two single-clock interrupt events fires: a request event for codec writes, or a reply event for codec reads.

The codec side sees the stored codec address and outgoing data as plain outputs. It returns read data through a strobe that loads the incoming-data register. The request bit never stays set, so the control register always reads back with bit 0 at zero. Only whole-word accesses exist, so the two lowest byte-address bits take no part in decoding.

Top module: `codec_reg_ctrl`

## Requirements
- R1: After reset, all four registers read zero and both interrupt outputs are low.
- R2: Register index is taken from bus_addr[3:2]: 0 = control, 1 = codec address, 2 = outgoing data, 3 = incoming data. Any upper address bit set means unmapped. Writes land at the clock edge where bus_sel and bus_we are high, and reads are combinational while bus_sel is high and bus_we is low.
- R3: A control write with bit 0 (request) = 1 and bit 1 (direction) = 1 drives irq_req high for exactly the one cycle after the write edge, while irq_rep stays low.
- R4: A control write with bit 0 = 1 and bit 1 = 0 drives irq_rep high for exactly the one cycle after the write edge, while irq_req stays low.
- R5: A control write with bit 0 = 0 raises neither interrupt, and the written value is still stored.
- R6: The control register reads back with bit 0 always zero, and every other written bit is kept.
- R7: bus_addr[1:0] have no effect on which register is read or written.
- R8: Reads of unmapped offsets return zero. Writes to them change no register and raise no interrupt.
- R9: A cycle with codec_rd_vld high loads codec_rd_data into the incoming-data register. If a bus write to that register occurs in the same cycle, the codec value is kept.
- R10: codec_addr and codec_dout always equal the codec address and outgoing-data registers, and they change only when those registers are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_req | output | 1 | One-cycle event for a codec write request |
| irq_rep | output | 1 | One-cycle event for a codec read request |
| codec_addr | output | 32 | Codec register address |
| codec_dout | output | 32 | Data to send to the codec |
| codec_rd_vld | input | 1 | Codec read-data strobe |
| codec_rd_data | input | 32 | Data returned by the codec |

## Verification
Register contents and interrupt events change at the rising edge that accepts a write. Interrupts are registered, so each one is high only in the cycle after that edge. The bench samples them at the following falling edge and again one cycle later to confirm they dropped. Read data needs no clock edge, so the bench samples bus_rdata at the falling edge where it presents the read address. A codec strobe or a colliding bus write is observed by a read in the cycle after its edge.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
    localparam int CRC_WORD_W = 32;
    localparam int CRC_NREG   = 4;
    localparam int CRC_IDX_W  = $clog2(CRC_NREG);
    localparam int CRC_LSB    = $clog2(CRC_WORD_W / 8);

    localparam logic [CRC_IDX_W-1:0] IDX_CTRL  = 2'd0;
    localparam logic [CRC_IDX_W-1:0] IDX_CADDR = 2'd1;
    localparam logic [CRC_IDX_W-1:0] IDX_DOUT  = 2'd2;
    localparam logic [CRC_IDX_W-1:0] IDX_DIN   = 2'd3;

    localparam int BIT_REQ = 0;
    localparam int BIT_DIR = 1;
endpackage

// File: rtl/crc_decode.sv
module crc_decode
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 sel,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    output logic [CRC_NREG-1:0]  wr_en,
    output logic [CRC_IDX_W-1:0] idx,
    output logic                 hit
);
    localparam int HI_LSB = CRC_LSB + CRC_IDX_W;

    logic [CRC_LSB-1:0] unused_lsb;

    assign unused_lsb = addr[CRC_LSB-1:0];
    assign idx        = addr[HI_LSB-1:CRC_LSB];
    assign hit        = (addr[ADDR_W-1:HI_LSB] == '0);

    for (genvar i = 0; i < CRC_NREG; i++) begin : g_wr
        assign wr_en[i] = sel && we && hit && (idx == CRC_IDX_W'(i));
    end
endmodule

// File: rtl/crc_regs.sv
module crc_regs
    import codec_reg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CRC_NREG-1:0]   wr_en,
    input  logic [CRC_WORD_W-1:0] wdata,
    input  logic                  cdc_vld,
    input  logic [CRC_WORD_W-1:0] cdc_data,
    output logic [CRC_WORD_W-1:0] ctrl,
    output logic [CRC_WORD_W-1:0] caddr,
    output logic [CRC_WORD_W-1:0] dout,
    output logic [CRC_WORD_W-1:0] din
);
    typedef struct packed {
        logic [CRC_WORD_W-1:0] ctrl;
        logic [CRC_WORD_W-1:0] caddr;
        logic [CRC_WORD_W-1:0] dout;
        logic [CRC_WORD_W-1:0] din;
    } regs_t;

    regs_t r_d, r_q;
    logic [CRC_WORD_W-1:0] keep_mask;

    always_comb begin
        keep_mask          = '1;
        keep_mask[BIT_REQ] = 1'b0;
        r_d = r_q;
        if (wr_en[IDX_CTRL])  r_d.ctrl  = wdata & keep_mask;
        if (wr_en[IDX_CADDR]) r_d.caddr = wdata;
        if (wr_en[IDX_DOUT])  r_d.dout  = wdata;
        if (cdc_vld)              r_d.din = cdc_data;
        else if (wr_en[IDX_DIN])  r_d.din = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl  = r_q.ctrl;
    assign caddr = r_q.caddr;
    assign dout  = r_q.dout;
    assign din   = r_q.din;
endmodule

// File: rtl/crc_event.sv
module crc_event (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic req_bit,
    input  logic dir_bit,
    output logic ev_req,
    output logic ev_rep
);
    typedef struct packed {
        logic req;
        logic rep;
    } ev_t;

    ev_t e_d, e_q;

    always_comb begin
        e_d.req = ctrl_wr && req_bit && dir_bit;
        e_d.rep = ctrl_wr && req_bit && !dir_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign ev_req = e_q.req;
    assign ev_rep = e_q.rep;
endmodule

// File: rtl/codec_reg_ctrl.sv
module codec_reg_ctrl
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CRC_WORD_W-1:0] bus_wdata,
    output logic [CRC_WORD_W-1:0] bus_rdata,
    output logic                  irq_req,
    output logic                  irq_rep,
    output logic [CRC_WORD_W-1:0] codec_addr,
    output logic [CRC_WORD_W-1:0] codec_dout,
    input  logic                  codec_rd_vld,
    input  logic [CRC_WORD_W-1:0] codec_rd_data
);
    logic [CRC_NREG-1:0]   wr_en;
    logic [CRC_IDX_W-1:0]  idx;
    logic                  hit;
    logic [CRC_WORD_W-1:0] ctrl_q, caddr_q, dout_q, din_q;

    crc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel   (bus_sel),
        .we    (bus_we),
        .addr  (bus_addr),
        .wr_en (wr_en),
        .idx   (idx),
        .hit   (hit)
    );

    crc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wdata    (bus_wdata),
        .cdc_vld  (codec_rd_vld),
        .cdc_data (codec_rd_data),
        .ctrl     (ctrl_q),
        .caddr    (caddr_q),
        .dout     (dout_q),
        .din      (din_q)
    );

    crc_event u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (wr_en[IDX_CTRL]),
        .req_bit (bus_wdata[BIT_REQ]),
        .dir_bit (bus_wdata[BIT_DIR]),
        .ev_req  (irq_req),
        .ev_rep  (irq_rep)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && hit) begin
            case (idx)
                IDX_CTRL:  bus_rdata = ctrl_q;
                IDX_CADDR: bus_rdata = caddr_q;
                IDX_DOUT:  bus_rdata = dout_q;
                default:   bus_rdata = din_q;
            endcase
        end
    end

    assign codec_addr = caddr_q;
    assign codec_dout = dout_q;
endmodule

// File: rtl/codec_reg_ctrl_chk.sv
module codec_reg_ctrl_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-3:0] word_addr,
    input logic [1:0]        wbits,
    input logic [31:0]       bus_rdata,
    input logic              irq_req,
    input logic              irq_rep,
    input logic [31:0]       codec_addr
);
    logic ctl_wr, caddr_wr, rd_any, rd_ctl, rd_unmapped;
    assign ctl_wr      = bus_sel && bus_we && (word_addr == '0);
    assign caddr_wr    = bus_sel && bus_we && (word_addr == (ADDR_W-2)'(1));
    assign rd_any      = bus_sel && !bus_we;
    assign rd_ctl      = rd_any && (word_addr == '0);
    assign rd_unmapped = rd_any && (word_addr[ADDR_W-3:2] != '0);

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wbits == 2'b11) |=> (irq_req && !irq_rep)); // R3
    AST_REP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wbits == 2'b01) |=> (irq_rep && !irq_req)); // R4
    AST_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && wbits[0]) |=> (!irq_req && !irq_rep)); // R5
    AST_CTRL_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |-> (bus_rdata[0] == 1'b0)); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |-> (bus_rdata == '0)); // R8
    AST_CADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !caddr_wr |=> $stable(codec_addr)); // R10
endmodule

bind codec_reg_ctrl codec_reg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .word_addr  (bus_addr[ADDR_W-1:2]),
    .wbits      (bus_wdata[1:0]),
    .bus_rdata  (bus_rdata),
    .irq_req    (irq_req),
    .irq_rep    (irq_rep),
    .codec_addr (codec_addr)
);

// File: tb/sim_codec_reg_ctrl.sv
module sim_codec_reg_ctrl;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req, irq_rep;
    logic [31:0]   codec_addr, codec_dout;
    logic          codec_rd_vld = 1'b0;
    logic [31:0]   codec_rd_data = '0;

    int n_chk = 0;
    int n_err = 0;
    logic ev_req_s, ev_rep_s;

    always #4 clk = ~clk;

    codec_reg_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_rep(irq_rep), .codec_addr(codec_addr),
        .codec_dout(codec_dout), .codec_rd_vld(codec_rd_vld),
        .codec_rd_data(codec_rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // write; captures interrupt levels in the cycle after the write edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        ev_req_s = irq_req; ev_rep_s = irq_rep;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(AW'(i*4), v);
            chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 irq_req after reset", {31'b0, irq_req}, 32'h0);
        chk("R1 irq_rep after reset", {31'b0, irq_rep}, 32'h0);
    endtask

    task automatic t_write_req;
        logic [31:0] v;
        wr(6'h00, 32'h0000_00A3);
        chk("R3 irq_req pulse", {31'b0, ev_req_s}, 32'h1);
        chk("R3 irq_rep quiet", {31'b0, ev_rep_s}, 32'h0);
        @(negedge clk);
        chk("R3 irq_req one cycle", {31'b0, irq_req}, 32'h0);
        rd(6'h00, v);
        chk("R6 ctrl readback bit0 cleared", v, 32'h0000_00A2);
    endtask

    task automatic t_read_rep;
        logic [31:0] v;
        wr(6'h00, 32'h8000_0001);
        chk("R4 irq_rep pulse", {31'b0, ev_rep_s}, 32'h1);
        chk("R4 irq_req quiet", {31'b0, ev_req_s}, 32'h0);
        @(negedge clk);
        chk("R4 irq_rep one cycle", {31'b0, irq_rep}, 32'h0);
        rd(6'h00, v);
        chk("R6 ctrl readback", v, 32'h8000_0000);
    endtask

    task automatic t_no_request;
        logic [31:0] v;
        wr(6'h00, 32'h0000_0002);
        chk("R5 no irq_req", {31'b0, ev_req_s}, 32'h0);
        chk("R5 no irq_rep", {31'b0, ev_rep_s}, 32'h0);
        rd(6'h00, v);
        chk("R5 value stored", v, 32'h0000_0002);
    endtask

    task automatic t_data_regs;
        logic [31:0] v;
        wr(6'h04, 32'h0000_0055);
        wr(6'h08, 32'hDEAD_BEEF);
        wr(6'h0C, 32'h0000_1234);
        rd(6'h04, v); chk("R2 codec address reg", v, 32'h0000_0055);
        rd(6'h08, v); chk("R2 data out reg", v, 32'hDEAD_BEEF);
        rd(6'h0C, v); chk("R2 data in reg", v, 32'h0000_1234);
        chk("R10 codec_addr port", codec_addr, 32'h0000_0055);
        chk("R10 codec_dout port", codec_dout, 32'hDEAD_BEEF);
    endtask

    task automatic t_lsb;
        logic [31:0] v;
        wr(6'h07, 32'h0000_0077);
        rd(6'h04, v); chk("R7 write with low bits 11", v, 32'h0000_0077);
        rd(6'h05, v); chk("R7 read with low bits 01", v, 32'h0000_0077);
        chk("R10 codec_addr follows", codec_addr, 32'h0000_0077);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(6'h10, 32'h0000_0003);
        chk("R8 no irq_req from unmapped", {31'b0, ev_req_s}, 32'h0);
        chk("R8 no irq_rep from unmapped", {31'b0, ev_rep_s}, 32'h0);
        wr(6'h38, 32'hFFFF_FFFF);
        wr(6'h14, 32'hAAAA_AAAA);
        rd(6'h10, v); chk("R8 unmapped read zero", v, 32'h0);
        rd(6'h00, v); chk("R8 ctrl untouched", v, 32'h0000_0002);
        rd(6'h04, v); chk("R8 codec address untouched", v, 32'h0000_0077);
        rd(6'h08, v); chk("R8 data out untouched", v, 32'hDEAD_BEEF);
        rd(6'h0C, v); chk("R8 data in untouched", v, 32'h0000_1234);
    endtask

    task automatic t_codec_load;
        logic [31:0] v;
        @(negedge clk);
        codec_rd_vld = 1'b1; codec_rd_data = 32'h0000_BEAD;
        @(negedge clk);
        codec_rd_vld = 1'b0;
        rd(6'h0C, v); chk("R9 codec strobe loads data in", v, 32'h0000_BEAD);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h1111_1111;
        codec_rd_vld = 1'b1; codec_rd_data = 32'h2222_2222;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; codec_rd_vld = 1'b0;
        rd(6'h0C, v); chk("R9 codec wins collision", v, 32'h2222_2222);
        wr(6'h0C, 32'h3333_3333);
        rd(6'h0C, v); chk("R9 bus write alone", v, 32'h3333_3333);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_req();
        t_read_rep();
        t_no_request();
        t_data_regs();
        t_lsb();
        t_unmapped();
        t_codec_load();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule